// File: doc/BRIEF.md
# Two-Channel Supply Margining Control Loop

This block holds the output of two trimmed power converters at a chosen setpoint. For each channel it keeps a digitized sample of the sensed output voltage. It compares that sample against one of three stored targets: nominal, margin-high or margin-low. A 2-bit command per channel selects the target. On a slow periodic tick the block moves the channel's trim drive code by a single step toward the target. A per-channel polarity setting decides whether a higher trim code raises or lowers the converter output.

A channel runs only when its control enable is set and the start input is at its active level. The start input's active level is configurable. While a channel is idle, its trim drive enable is low, so the analog trim buffer is released, and its trim code is frozen.

Each channel has a ready flag. The flag is set when the sensed sample comes within a programmable tolerance of the target. It is cleared while the channel moves toward a new target. A combined ready pin with a configurable active level shows that all enabled channels are at their setpoints. An optional fast mode takes larger steps while the error is large, which shortens long moves such as the first pull-in to nominal. The tick comes from a prescaler whose division ratio is a parameter.

Top module: `supply_margin_ctrl`

## Requirements
- R1: After reset, every trim code equals mid-scale (2^(TRIM_W-1), 512 for a 10-bit code), every trim drive enable is 0, every ready flag is 0, and the ready pin sits at its inactive level.
- R2: The 2-bit command selects the target for its channel: 00 selects nominal, 01 selects margin-high, 10 selects margin-low, and 11 also selects nominal. The loop settles the sense sample onto the selected target.
- R3: A running channel changes its trim code at most once per tick period (TICK_DIV clock cycles). In normal mode each change is exactly 1 LSB.
- R4: The step direction depends on the channel's polarity. With trim_invert=0, a sample below target increments the code and a sample above target decrements it. With trim_invert=1, both directions are reversed.
- R5: With fast_mode set, the step is FAST_STEP (8) while the absolute error exceeds FAST_THRESH (32). At an error of 32 or less the step is 1.
- R6: The trim code saturates at 0 and at 2^TRIM_W-1 and never wraps.
- R7: A channel runs only when ctrl_en is 1 and start is active. While a channel is idle, its trim_oe is 0, its trim code holds, and its ready flag is 0.
- R8: Start is active when start_pin equals start_active_high.
- R9: On a tick, a running channel whose absolute error is at most the tolerance sets its ready flag and takes no step. A change of that channel's command clears its ready flag on the next clock edge.
- R10: The ready pin equals ready_active_high when start is active, at least one channel is enabled, and every enabled channel is ready. Otherwise it equals the inverse of ready_active_high.
- R11: After a margin move, writing the nominal code back returns the channel to its nominal target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_pin | input | 1 | Start input level |
| start_active_high | input | 1 | 1: start is active high; 0: start is active low |
| ready_active_high | input | 1 | Active level of ready_pin |
| ctrl_en | input | NCH | Per-channel control enable |
| trim_invert | input | NCH | Per-channel trim polarity (1: a higher code lowers the output) |
| fast_mode | input | NCH | Per-channel fast convergence enable |
| tolerance | input | TOL_W | Ready band in sense LSBs |
| margin_cmd | input | 2*NCH | Per-channel target select, 2 bits each, channel 0 in the low bits |
| set_nom | input | NCH*SENSE_W | Nominal targets |
| set_high | input | NCH*SENSE_W | Margin-high targets |
| set_low | input | NCH*SENSE_W | Margin-low targets |
| sense_valid | input | NCH | Sense sample strobe per channel |
| sense_data | input | NCH*SENSE_W | Sense samples |
| trim_code | output | NCH*TRIM_W | Trim drive codes |
| trim_oe | output | NCH | Trim buffer enable (0 means released) |
| ready_status | output | NCH | Per-channel ready flags |
| ready_pin | output | 1 | Combined ready level |

## Verification
A wrong step size or a wrong direction shows on trim_code one tick period after the fault, as a code difference other than ±1, ±8 or 0. A corrupted target select or polarity can produce a code that converges to the wrong place; when it does, it appears as a settled trim code that differs from the code the plant model predicts, or as a ready flag that never rises. Ready bookkeeping faults show within two clock edges of a command change, as a ready flag or pin level that fails to drop.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {
    MC_NOM  = 2'b00,
    MC_HIGH = 2'b01,
    MC_LOW  = 2'b10,
    MC_NOM2 = 2'b11
  } margin_cmd_e;

  typedef struct packed {
    logic invert;
    logic fast;
  } ch_cfg_t;

endpackage

// File: rtl/smc_tick.sv
module smc_tick #(
  parameter int TICK_DIV = 425000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = $clog2(TICK_DIV);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      cnt  <= wrap ? '0 : cnt + 1'b1;
    end
  end

  // R3: ticks are isolated single-cycle pulses
  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R3: the prescaler never leaves its range
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/smc_chan.sv
module smc_chan
  import smc_pkg::*;
#(
  parameter int SENSE_W     = 16,
  parameter int TRIM_W      = 10,
  parameter int TOL_W       = 4,
  parameter int FAST_STEP   = 8,
  parameter int FAST_THRESH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               run,
  input  ch_cfg_t            cfg,
  input  margin_cmd_e        cmd,
  input  logic [TOL_W-1:0]   tol,
  input  logic [SENSE_W-1:0] set_nom,
  input  logic [SENSE_W-1:0] set_high,
  input  logic [SENSE_W-1:0] set_low,
  input  logic               sense_valid,
  input  logic [SENSE_W-1:0] sense,
  output logic [TRIM_W-1:0]  trim_code,
  output logic               ready
);
  localparam logic [TRIM_W-1:0]  TRIM_MAX  = {TRIM_W{1'b1}};
  localparam logic [TRIM_W-1:0]  TRIM_INIT = TRIM_W'(1) << (TRIM_W - 1);
  localparam logic [TRIM_W-1:0]  STEP_BIG  = TRIM_W'(FAST_STEP);
  localparam logic [SENSE_W-1:0] THRESH    = SENSE_W'(FAST_THRESH);
  localparam int                 PADW      = SENSE_W - TOL_W;

  function automatic logic [SENSE_W-1:0] f_abs_diff(
      input logic [SENSE_W-1:0] a, input logic [SENSE_W-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [TRIM_W-1:0] f_step(
      input logic [SENSE_W-1:0] mag, input logic fast);
    return (fast && (mag > THRESH)) ? STEP_BIG : TRIM_W'(1);
  endfunction

  function automatic logic [TRIM_W-1:0] f_move(
      input logic [TRIM_W-1:0] code, input logic up, input logic [TRIM_W-1:0] step);
    if (up) return (code > (TRIM_MAX - step)) ? TRIM_MAX : (code + step);
    else    return (code < step) ? '0 : (code - step);
  endfunction

  logic [SENSE_W-1:0] sample;
  logic               have;
  logic [SENSE_W-1:0] target;
  logic [SENSE_W-1:0] err_mag;
  logic               in_tol;
  logic               raise_out;
  logic               code_up;
  logic [TRIM_W-1:0]  step;
  logic [TRIM_W-1:0]  code_nxt;
  margin_cmd_e        cmd_q;
  logic               cmd_chg;
  logic               step_evt;

  always_comb begin
    case (cmd)
      MC_HIGH: target = set_high;
      MC_LOW:  target = set_low;
      MC_NOM,
      MC_NOM2: target = set_nom;
      default: target = set_nom;
    endcase
  end

  assign err_mag   = f_abs_diff(target, sample);
  assign in_tol    = have && (err_mag <= {{PADW{1'b0}}, tol});
  assign raise_out = (target > sample);
  assign code_up   = raise_out ^ cfg.invert;
  assign step      = f_step(err_mag, cfg.fast);
  assign code_nxt  = f_move(trim_code, code_up, step);
  assign cmd_chg   = (cmd != cmd_q);
  assign step_evt  = run && !cmd_chg && tick && have && !in_tol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample    <= '0;
      have      <= 1'b0;
      trim_code <= TRIM_INIT;
      ready     <= 1'b0;
      cmd_q     <= MC_NOM;
    end else begin
      cmd_q <= cmd;
      if (sense_valid) begin
        sample <= sense;
        have   <= 1'b1;
      end
      if (!run || cmd_chg) begin
        ready <= 1'b0;
      end else if (tick && have) begin
        ready <= in_tol;
      end
      if (step_evt) trim_code <= code_nxt;
    end
  end

  // R7: an idle channel keeps its code
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (trim_code == $past(trim_code)));

  // R7: an idle channel drops ready
  a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !ready);

  // R3: no code change without a tick
  a_r3_no_step_between: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(trim_code));

  // R5: a single update never moves more than the fast step
  a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (((trim_code >= $past(trim_code)) ? (trim_code - $past(trim_code))
                                               : ($past(trim_code) - trim_code)) <= STEP_BIG));

  // R9: ready rises only after an in-band sample
  a_r9_ready_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(in_tol));

  // R9: a command change clears ready
  a_r9_cmd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_chg |=> !ready);

endmodule

// File: rtl/smc_ready_pin.sv
module smc_ready_pin #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_act,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] rdy,
  input  logic           active_high,
  output logic           pin
);
  logic all_ok;
  logic pin_active;

  assign all_ok     = &(rdy | ~en);
  assign pin_active = start_act && (|en) && all_ok;
  assign pin        = pin_active ? active_high : ~active_high;

  // R10: pin active implies at least one channel ready
  a_r10_pin_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (pin == active_high) |-> (|rdy));

  // R10: any enabled laggard holds the pin inactive
  a_r10_laggard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en & ~rdy)) |-> (pin != active_high));

endmodule

// File: rtl/supply_margin_ctrl.sv
module supply_margin_ctrl
  import smc_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SENSE_W     = 16,
  parameter int TRIM_W      = 10,
  parameter int TOL_W       = 4,
  parameter int FAST_STEP   = 8,
  parameter int FAST_THRESH = 32,
  parameter int TICK_DIV    = 425000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_pin,
  input  logic                   start_active_high,
  input  logic                   ready_active_high,
  input  logic [NCH-1:0]         ctrl_en,
  input  logic [NCH-1:0]         trim_invert,
  input  logic [NCH-1:0]         fast_mode,
  input  logic [TOL_W-1:0]       tolerance,
  input  logic [2*NCH-1:0]       margin_cmd,
  input  logic [NCH*SENSE_W-1:0] set_nom,
  input  logic [NCH*SENSE_W-1:0] set_high,
  input  logic [NCH*SENSE_W-1:0] set_low,
  input  logic [NCH-1:0]         sense_valid,
  input  logic [NCH*SENSE_W-1:0] sense_data,
  output logic [NCH*TRIM_W-1:0]  trim_code,
  output logic [NCH-1:0]         trim_oe,
  output logic [NCH-1:0]         ready_status,
  output logic                   ready_pin
);
  logic           tick;
  logic           start_act;
  logic [NCH-1:0] run;

  assign start_act = (start_pin == start_active_high);
  assign run       = ctrl_en & {NCH{start_act}};
  assign trim_oe   = run;

  smc_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ch_cfg_t cfg;
    assign cfg.invert = trim_invert[i];
    assign cfg.fast   = fast_mode[i];

    smc_chan #(
      .SENSE_W    (SENSE_W),
      .TRIM_W     (TRIM_W),
      .TOL_W      (TOL_W),
      .FAST_STEP  (FAST_STEP),
      .FAST_THRESH(FAST_THRESH)
    ) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .run        (run[i]),
      .cfg        (cfg),
      .cmd        (margin_cmd_e'(margin_cmd[2*i +: 2])),
      .tol        (tolerance),
      .set_nom    (set_nom[SENSE_W*i +: SENSE_W]),
      .set_high   (set_high[SENSE_W*i +: SENSE_W]),
      .set_low    (set_low[SENSE_W*i +: SENSE_W]),
      .sense_valid(sense_valid[i]),
      .sense      (sense_data[SENSE_W*i +: SENSE_W]),
      .trim_code  (trim_code[TRIM_W*i +: TRIM_W]),
      .ready      (ready_status[i])
    );
  end

  smc_ready_pin #(.NCH(NCH)) u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_act  (start_act),
    .en         (ctrl_en),
    .rdy        (ready_status),
    .active_high(ready_active_high),
    .pin        (ready_pin)
  );

  // R7: the trim buffer is released whenever start is inactive
  a_r7_oe_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pin != start_active_high) |-> (trim_oe == '0));

endmodule

// File: tb/tb_supply_margin_ctrl.sv
`timescale 1ns/1ps
module tb_supply_margin_ctrl;
  localparam int NCH  = 2;
  localparam int SW   = 16;
  localparam int TW   = 10;
  localparam int TOLW = 4;
  localparam int TDIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            start_pin, start_active_high, ready_active_high;
  logic [1:0]      ctrl_en, trim_invert, fast_mode;
  logic [TOLW-1:0] tolerance;
  logic [3:0]      margin_cmd;
  logic [31:0]     set_nom, set_high, set_low;
  logic [1:0]      sense_valid;
  logic [31:0]     sense_data;
  logic [19:0]     trim_code;
  logic [1:0]      trim_oe, ready_status;
  logic            ready_pin;

  logic            plant_on;
  logic [15:0]     force0, force1, m0, m1;

  // plant: channel 0 rises with code, channel 1 falls with code
  always_comb begin
    m0 = 16'd1000 + {4'd0, trim_code[9:0], 2'b00};
    m1 = 16'd5000 - {4'd0, trim_code[19:10], 2'b00};
  end
  assign sense_data  = plant_on ? {m1, m0} : {force1, force0};
  assign sense_valid = 2'b11;

  supply_margin_ctrl #(
    .NCH(NCH), .SENSE_W(SW), .TRIM_W(TW), .TOL_W(TOLW),
    .FAST_STEP(8), .FAST_THRESH(32), .TICK_DIV(TDIV)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_pin(start_pin),
    .start_active_high(start_active_high), .ready_active_high(ready_active_high),
    .ctrl_en(ctrl_en), .trim_invert(trim_invert), .fast_mode(fast_mode),
    .tolerance(tolerance), .margin_cmd(margin_cmd), .set_nom(set_nom),
    .set_high(set_high), .set_low(set_low), .sense_valid(sense_valid),
    .sense_data(sense_data), .trim_code(trim_code), .trim_oe(trim_oe),
    .ready_status(ready_status), .ready_pin(ready_pin)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int c0();
    return int'(trim_code[9:0]);
  endfunction
  function automatic int c1();
    return int'(trim_code[19:10]);
  endfunction

  task automatic periods(input int n);
    repeat (n * TDIV) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_ready(input logic [1:0] exp, input int maxcyc);
    for (int k = 0; k < maxcyc; k++) begin
      if (ready_status == exp) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 code0", c0(), 512);
    chk("R1 code1", c1(), 512);
    chk("R1 oe", int'(trim_oe), 0);
    chk("R1 ready", int'(ready_status), 0);
    chk("R1 pin", int'(ready_pin), 0);
  endtask

  task automatic t_idle_start();
    periods(5);
    chk("R7 idle code0", c0(), 512);
    chk("R8 inactive start oe", int'(trim_oe), 0);
    start_active_high = 1'b0;   // start_pin=0 now counts as active
    @(negedge clk);
    chk("R8 active-low start oe", int'(trim_oe), 3);
    periods(3);
    chk("R9 in-band no step code0", c0(), 512);
    chk("R9 ready set", int'(ready_status), 3);
    chk("R10 pin active high", int'(ready_pin), 1);
  endtask

  task automatic t_step_dir();
    int a0, a1;
    force0 = 16'd1000;
    force1 = 16'd1000;
    periods(1);
    a0 = c0(); a1 = c1();
    periods(1);
    chk("R3 one LSB per period ch0", c0() - a0, 1);
    chk("R4 inverted ch1 down", c1() - a1, -1);
    a0 = c0(); a1 = c1();
    periods(3);
    chk("R3 three periods ch0", c0() - a0, 3);
    chk("R4 three periods ch1", c1() - a1, -3);
    chk("R9 ready cleared off target", int'(ready_status), 0);
    chk("R10 pin inactive", int'(ready_pin), 0);
  endtask

  task automatic t_fast();
    int a0, a1;
    fast_mode = 2'b11;
    periods(1);
    a0 = c0(); a1 = c1();
    periods(1);
    chk("R5 far step ch0", c0() - a0, 8);
    chk("R5 far step ch1", c1() - a1, -8);
    force0 = 16'd3067;          // error 33
    force1 = 16'd2868;          // error 32
    periods(1);
    a0 = c0(); a1 = c1();
    periods(1);
    chk("R5 error 33 fast", c0() - a0, 8);
    chk("R5 error 32 slow", c1() - a1, -1);
  endtask

  task automatic t_sat();
    force0 = 16'd1000;
    force1 = 16'd1000;
    periods(200);
    chk("R6 top clamp", c0(), 1023);
    chk("R6 bottom clamp", c1(), 0);
    periods(2);
    chk("R6 no wrap top", c0(), 1023);
    chk("R6 no wrap bottom", c1(), 0);
  endtask

  task automatic t_converge();
    plant_on = 1'b1;
    wait_ready(2'b11, 4000);
    chk("R2 nominal settle ch0", c0(), 525);
    chk("R2 nominal settle ch1", c1(), 525);
    chk("R9 both ready", int'(ready_status), 3);
    chk("R10 pin ready", int'(ready_pin), 1);
  endtask

  task automatic t_margin();
    margin_cmd = 4'b10_01;      // ch1 low, ch0 high
    @(negedge clk);
    @(negedge clk);
    chk("R9 command change clears ready", int'(ready_status), 0);
    chk("R10 pin drops on move", int'(ready_pin), 0);
    wait_ready(2'b11, 4000);
    chk("R2 margin high ch0", c0(), 575);
    chk("R2 margin low ch1", c1(), 550);
    margin_cmd = 4'b00_11;      // ch1 nominal, ch0 alternate nominal code
    @(negedge clk);
    @(negedge clk);
    wait_ready(2'b11, 4000);
    chk("R11 back to nominal ch0 (code 11)", c0(), 525);
    chk("R11 back to nominal ch1", c1(), 525);
  endtask

  task automatic t_pin_disable();
    ready_active_high = 1'b0;
    @(negedge clk);
    chk("R10 active-low pin", int'(ready_pin), 0);
    plant_on = 1'b0;
    force0 = 16'd3100;
    force1 = 16'd1000;
    ctrl_en = 2'b01;
    @(negedge clk);
    chk("R7 oe released ch1", int'(trim_oe), 1);
    periods(4);
    chk("R7 disabled ch1 holds", c1(), 525);
    chk("R7 disabled ch1 not ready", int'(ready_status[1]), 0);
    chk("R10 pin follows enabled ch0", int'(ready_pin), 0);
    ctrl_en = 2'b00;
    @(negedge clk);
    chk("R10 none enabled inactive", int'(ready_pin), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    start_pin = 1'b0; start_active_high = 1'b1; ready_active_high = 1'b1;
    ctrl_en = 2'b11; trim_invert = 2'b10; fast_mode = 2'b00;
    tolerance = 4'd2; margin_cmd = 4'b0000;
    set_nom  = {16'd2900, 16'd3100};
    set_high = {16'd3000, 16'd3300};
    set_low  = {16'd2800, 16'd2900};
    plant_on = 1'b0; force0 = 16'd3100; force1 = 16'd2900;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_start();
    t_step_dir();
    t_fast();
    t_sat();
    t_converge();
    t_margin();
    t_pin_disable();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule